// File: doc/BRIEF.md
# Dual-Timer Trigger Generator

This block produces the start signal for an analog-to-digital converter that samples a supply-current waveform at a steady rate. Two auto-reloading down-counters run side by side. When the first one (the "set" timer) reaches zero, the trigger level goes high. When the second one (the "clear" timer) reaches zero, the trigger level goes low. The converter is started only on a rising edge of the trigger, and the block marks that edge with a one-cycle start pulse.

The clear timer is meant to run at twice the rate of the set timer. Its period is then half the set period, so the trigger always falls once between two consecutive rises. Both periods come from reload inputs. These inputs are captured when the enable input rises and are ignored while the block runs.

The trigger logic has a single state. Its outputs are formed in the same cycle from the current timer events and the trigger level held from the previous cycle. The first enabled cycle is the cycle that follows the clock edge at which enable is first seen high. This first enabled cycle is counted as cycle 0.

Top module: `dual_timer_trigger`

## Requirements
- R1: While reset is active, and after reset while enable is low, `trigger` and `convStart` are both 0.
- R2: Each timer loads its reload value R on cycle 0, counts down by one per cycle, and reloads R on the cycle after it reads zero. Its event therefore fires in cycles R, 2R+1, 3R+2, and so on (period R+1, where R = 0 fires every cycle).
- R3: In a cycle with a set event, `trigger` is 1. In a cycle with a clear event and no set event, `trigger` is 0. In a cycle with neither event, `trigger` keeps its value from the previous cycle.
- R4: When set and clear events fire in the same cycle, the set event wins and `trigger` is 1.
- R5: `convStart` is 1 for exactly the cycles in which `trigger` is 1 and was 0 in the previous cycle.
- R6: While enable is low, `trigger` and `convStart` are 0 and both timers are held at their reload inputs. Raising enable again restarts both timers at cycle 0.
- R7: The reload values are captured on the clock edge at which enable is first seen high. Changing `setReload` or `clrReload` while enabled has no effect on the outputs.
- R8: With an odd set reload S and a clear reload of (S-1)/2, each set period holds exactly one `convStart`, and `trigger` is low in at least one cycle between any two `convStart` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the timers when high; holds them and the trigger low when low |
| setReload | input | CNT_W (16) | Reload value of the set timer, captured when enable rises |
| clrReload | input | CNT_W (16) | Reload value of the clear timer, captured when enable rises |
| trigger | output | 1 | Trigger level to the converter |
| convStart | output | 1 | One-cycle pulse on each rising edge of the trigger |

## Verification
The case that is hardest to reach from the ports is a set event and a clear event landing in the same cycle after several reloads, because that needs particular pairs of reload values. The bench sweeps every pair of set and clear reloads from 0 to 9. For each pair it runs many set periods and compares every cycle against event times computed from the arithmetic of R2. This reaches all coincidence phases, including the half-rate pairs. Each run also changes the reload inputs in the middle of the run and disables the block at the end. These steps cover the rules for input capture and for holding the block idle.

// File: rtl/dual_trig_pkg.sv
package dual_trig_pkg;

  localparam int NUM_TMR = 2;
  localparam int SET_IDX = 0;
  localparam int CLR_IDX = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture reload inputs into both timers
    logic run;    // timers count this cycle
  } trigStrobe_t;

  // events from datapath to control
  typedef struct packed {
    logic setHit;
    logic clrHit;
  } trigEvent_t;

endpackage

// File: rtl/dtt_timer.sv
module dtt_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] reloadIn,
  output logic             hit
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] heldReload;
  logic             atZero;

  assign atZero = (count == ZERO);
  assign hit    = run && atZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= ZERO;
      heldReload <= ZERO;
    end else if (load) begin
      count      <= reloadIn;
      heldReload <= reloadIn;
    end else if (run) begin
      if (atZero) count <= heldReload;
      else        count <= count - ONE;
    end
  end

endmodule

// File: rtl/dtt_datapath.sv
module dtt_datapath
  import dual_trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  trigStrobe_t                     strb,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   reloads,
  output trigEvent_t                      evt
);

  logic [NUM_TMR-1:0] hits;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dtt_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strb.load),
      .run      (strb.run),
      .reloadIn (reloads[i]),
      .hit      (hits[i])
    );
  end

  assign evt.setHit = hits[SET_IDX];
  assign evt.clrHit = hits[CLR_IDX];

endmodule

// File: rtl/dtt_control.sv
module dtt_control
  import dual_trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  trigEvent_t  evt,
  output trigStrobe_t strb,
  output logic        trigger,
  output logic        convStart
);

  logic armed;
  logic trigQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      trigQ <= 1'b0;
    end else begin
      armed <= enable;
      trigQ <= trigger;
    end
  end

  always_comb begin
    strb.run  = enable && armed;
    strb.load = !(enable && armed);
  end

  // single-state Mealy: set beats clear, otherwise hold
  always_comb begin
    trigger = 1'b0;
    if (strb.run) begin
      if (evt.setHit)      trigger = 1'b1;
      else if (evt.clrHit) trigger = 1'b0;
      else                 trigger = trigQ;
    end
  end

  assign convStart = trigger && !trigQ;

endmodule

// File: rtl/dual_timer_trigger.sv
module dual_timer_trigger
  import dual_trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] setReload,
  input  logic [CNT_W-1:0] clrReload,
  output logic             trigger,
  output logic             convStart
);

  trigStrobe_t                   strb;
  trigEvent_t                    evt;
  logic [NUM_TMR-1:0][CNT_W-1:0] reloads;

  always_comb begin
    reloads[SET_IDX] = setReload;
    reloads[CLR_IDX] = clrReload;
  end

  dtt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reloads (reloads),
    .evt     (evt)
  );

  dtt_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .evt       (evt),
    .strb      (strb),
    .trigger   (trigger),
    .convStart (convStart)
  );

endmodule

// File: rtl/dtt_checker.sv
module dtt_checker
  import dual_trig_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input trigStrobe_t strb,
  input trigEvent_t  evt,
  input logic        trigger,
  input logic        convStart
);

  p_events_only_running_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evt.setHit || evt.clrHit) |-> strb.run);

  p_clear_lowers_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evt.clrHit && !evt.setHit) |-> !trigger);

  p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !evt.setHit && !evt.clrHit) |-> (trigger == $past(trigger)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    evt.setHit |-> trigger);

  p_start_on_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (trigger && !$past(trigger)));

  p_rise_starts_r5: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && !$past(trigger)) |-> convStart);

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!trigger && !convStart));

endmodule

bind dual_timer_trigger dtt_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .strb      (strb),
  .evt       (evt),
  .trigger   (trigger),
  .convStart (convStart)
);

// File: tb/dual_timer_trigger_tb.sv
module dual_timer_trigger_tb_top;

  localparam int CNT_W = 16;
  localparam int MAXR  = 9;
  localparam int RUNLEN = 36;

  logic             clk = 1'b0;
  logic             rstN;
  logic             enable;
  logic [CNT_W-1:0] setReload;
  logic [CNT_W-1:0] clrReload;
  logic             trigger;
  logic             convStart;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  dual_timer_trigger #(.CNT_W(CNT_W)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .setReload (setReload),
    .clrReload (clrReload),
    .trigger   (trigger),
    .convStart (convStart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit evtAt(input int t, input int r);
    return (t >= r) && (((t - r) % (r + 1)) == 0);
  endfunction

  task automatic runCfg(input int s, input int c);
    bit prev = 1'b0;
    bit halfCfg;
    bit sawLow = 1'b1;
    bit seenStart = 1'b0;
    int starts = 0;
    int sets = 0;
    halfCfg = (2 * (c + 1) == s + 1);
    setReload = CNT_W'(s);
    clrReload = CNT_W'(c);
    @(negedge clk);
    check(trigger == 1'b0, "R6 idle trigger", trigger, 0);
    enable = 1'b1;
    for (int t = 0; t < RUNLEN; t++) begin
      bit se, ce, expT, expS;
      string tag;
      @(negedge clk);
      se = evtAt(t, s);
      ce = evtAt(t, c);
      expT = se ? 1'b1 : (ce ? 1'b0 : prev);
      expS = expT && !prev;
      if (se && ce)   tag = "R4 trigger";
      else if (se)    tag = "R2 trigger";
      else if (t > 3) tag = "R7 trigger";
      else            tag = "R3 trigger";
      check(trigger == expT, tag, trigger, expT);
      check(convStart == expS, "R5 convStart", convStart, expS);
      if (halfCfg) begin
        if (convStart) begin
          if (seenStart) check(sawLow, "R8 low between starts", sawLow, 1);
          seenStart = 1'b1;
          sawLow = 1'b0;
          starts++;
        end
        if (!trigger) sawLow = 1'b1;
        if (se) sets++;
      end
      prev = expT;
      if (t == 3) begin
        setReload = CNT_W'(s + 7);
        clrReload = 16'hFFFF;
      end
    end
    if (halfCfg) check(starts == sets, "R8 one start per period", starts, sets);
    enable = 1'b0;
    @(negedge clk);
    check(trigger == 1'b0, "R6 trigger after disable", trigger, 0);
    check(convStart == 1'b0, "R6 convStart after disable", convStart, 0);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    enable = 1'b0;
    setReload = '0;
    clrReload = '0;
    repeat (3) @(negedge clk);
    check(trigger == 1'b0, "R1 trigger in reset", trigger, 0);
    check(convStart == 1'b0, "R1 convStart in reset", convStart, 0);
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(trigger == 1'b0, "R1 trigger idle after reset", trigger, 0);
      check(convStart == 1'b0, "R1 convStart idle after reset", convStart, 0);
    end
    for (int s = 0; s <= MAXR; s++) begin
      for (int c = 0; c <= MAXR; c++) begin
        runCfg(s, c);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule